// File: doc/BRIEF.md
# Nibble-Tunnelled Parallel Register Target

This block is the device end of a byte-wide host output port paired with a narrow status return path. The host sends every command and every data value as a byte on `hd_i`. The top three bits of that byte name an operation: latch a write target, latch a read source, end the command, or carry a data nibble. The low four bits carry a register number or a nibble value. Bit 4 picks the upper or lower half of a register. Read data comes back four bits at a time on bits 6 to 3 of `st_o`.

Behind the port there is a bank of byte-wide registers and one extra port that opens onto a small buffer memory. That buffer port walks through memory with an internal pointer, so a host can stream bytes in or out with no address traffic. The device acts only when the host byte changes value. This lets a host repeat each byte for cable settling without side effects. A second read method is also available. When it is enabled, a separate host control line picks the returned nibble in place of bit 4 of the data byte.

Top module: `nib_port_target`

## Requirements
- R1: After reset every register and buffer byte is zero, the pointer is zero, the interface is idle with nothing latched, and `st_o` is 8'h00.
- R2: A new byte with bits [7:5] = 3'b111 returns the interface to idle. Data nibbles sent while idle change no register.
- R3: A new byte with bits [7:5] = 3'b010 latches bits [3:0] as the write target. In the write state, a byte with bit 7 = 0 and bit 6 = 0 writes its bits [3:0] into the target's low nibble when bit 4 = 0, and into its high nibble when bit 4 = 1.
- R4: A new byte with bits [7:5] = 3'b110 latches bits [3:0] as the read source. While reading, `st_o[6:3]` shows the source's high nibble if bit 4 of the latest accepted command or data byte is 1, and its low nibble if that bit is 0. `st_o[7]` and `st_o[2:0]` are always 0. The output follows one clock after the byte.
- R5: A byte equal to the previously accepted byte has no effect. The value compared against after reset is 8'hE0.
- R6: While `alt_rd_i` = 1, the returned nibble is the low one when `alt_lo_i` = 1 and the high one when `alt_lo_i` = 0, one clock after the inputs change.
- R7: Register number 14 is the buffer port. A low nibble written there is staged. A high nibble stores {high, staged low} at the pointer and then steps the pointer, which wraps from 15 to 0.
- R8: Reading register 14 returns the buffer byte at the pointer. When the interface leaves the high-nibble view of register 14, the pointer steps by one. Leaving it means moving to the low nibble, ending, or changing command.
- R9: Register 15 reads as zero and ignores writes. Bytes with bits [7:5] of 3'b011, 3'b100 or 3'b101 are ignored and leave the state and the nibble selection unchanged.
- R10: Outside the read state `st_o` is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hd_i | input | 8 | Host command/data byte |
| alt_rd_i | input | 1 | Selects the control-line nibble select for reads |
| alt_lo_i | input | 1 | Control-line select: 1 picks the low nibble |
| st_o | output | 8 | Status return, nibble on bits 6:3 |

## Verification
The bench sends repeated identical bytes to the buffer port. A design that acted on every byte instead of on changes would store a byte twice, and every later buffer read would land one place off. It reads the buffer port across the full depth and past the wrap. A pointer that stepped on the wrong nibble transition, or not at all when a command ends, would return bytes shifted by one or repeat a byte. Register 15, the reserved operation codes and data nibbles sent while idle are each followed by a read-back. A decoder that let any of them through would corrupt a visible register or drop the selected nibble.

// File: rtl/npt_pkg.sv
package npt_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  localparam int RAW    = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WR   = 2'd1,
    ST_RD   = 2'd2
  } npt_state_e;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_END   = 3'd1,
    OP_WADDR = 3'd2,
    OP_RADDR = 3'd3,
    OP_DATA  = 3'd4
  } npt_op_e;
endpackage

// File: rtl/npt_decode.sv
module npt_decode
  import npt_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  output npt_op_e           op_o,
  output logic [RAW-1:0]    reg_o,
  output logic              hi_o,
  output logic [NIB_W-1:0]  nib_o
);
  always_comb begin
    unique case (byte_i[7:5])
      3'b111:         op_o = OP_END;
      3'b010:         op_o = OP_WADDR;
      3'b110:         op_o = OP_RADDR;
      3'b000, 3'b001: op_o = OP_DATA;
      default:        op_o = OP_NONE;
    endcase
  end

  assign reg_o = byte_i[RAW-1:0];
  assign nib_o = byte_i[NIB_W-1:0];
  assign hi_o  = byte_i[4];
endmodule

// File: rtl/npt_regbank.sv
module npt_regbank
  import npt_pkg::*;
#(
  parameter int NREG = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RAW-1:0]    wsel_i,
  input  logic              we_lo_i,
  input  logic              we_hi_i,
  input  logic [NIB_W-1:0]  nib_i,
  input  logic [RAW-1:0]    rsel_i,
  output logic [BYTE_W-1:0] rdata_o
);
  logic [BYTE_W-1:0] rd_arr [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [BYTE_W-1:0] q;
    logic [BYTE_W-1:0] d;
    logic              en;

    assign en = (wsel_i == RAW'(g)) && (we_lo_i || we_hi_i);

    always_comb begin
      d = q;
      if (we_lo_i) d[NIB_W-1:0]      = nib_i;
      if (we_hi_i) d[BYTE_W-1:NIB_W] = nib_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign rd_arr[g] = q;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NREG; i++)
      if (rsel_i == RAW'(i)) rdata_o = rd_arr[i];
  end
endmodule

// File: rtl/npt_bufmem.sv
module npt_bufmem
  import npt_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_i,
  input  logic [BYTE_W-1:0]        wdata_i,
  input  logic                     adv_i,
  output logic [BYTE_W-1:0]        rdata_o,
  output logic [$clog2(DEPTH)-1:0] ptr_o
);
  localparam int PW = $clog2(DEPTH);

  logic [BYTE_W-1:0] mem_q [DEPTH];
  logic [PW-1:0]     ptr_q;
  logic [PW-1:0]     ptr_d;
  logic              ptr_en;

  assign ptr_en = wr_i || adv_i;

  always_comb begin
    ptr_d = ptr_q;
    if (ptr_en) ptr_d = (ptr_q == PW'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (ptr_en) ptr_q <= ptr_d;
      if (wr_i)   mem_q[ptr_q] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[ptr_q];
  assign ptr_o   = ptr_q;
endmodule

// File: rtl/nib_port_target.sv
module nib_port_target
  import npt_pkg::*;
#(
  parameter int NREG  = 14,
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] hd_i,
  input  logic              alt_rd_i,
  input  logic              alt_lo_i,
  output logic [BYTE_W-1:0] st_o
);
  localparam logic [RAW-1:0] BUF_IDX = RAW'(NREG);
  localparam int             PW      = $clog2(DEPTH);

  logic [1:0] rst_sync_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  npt_state_e        state_q, state_d;
  logic [BYTE_W-1:0] last_q;
  logic [RAW-1:0]    tgt_q, tgt_d, src_q, src_d;
  logic              rdhi_q, rdhi_d;
  logic [NIB_W-1:0]  stage_q, stage_d;
  logic              alt_q, alo_q;

  npt_op_e          op;
  logic [RAW-1:0]   dreg;
  logic             dhi;
  logic [NIB_W-1:0] dnib;
  logic             ev;
  logic             we_lo, we_hi, buf_we;
  logic             sel_cur, sel_nxt, bh_cur, bh_nxt, adv;
  logic [BYTE_W-1:0] bank_rd, buf_rd, src_byte;
  logic [NIB_W-1:0]  nib_out;
  logic [PW-1:0]     buf_ptr;

  npt_decode u_dec (
    .byte_i (hd_i),
    .op_o   (op),
    .reg_o  (dreg),
    .hi_o   (dhi),
    .nib_o  (dnib)
  );

  assign ev = (hd_i != last_q);

  always_comb begin
    state_d = state_q;
    tgt_d   = tgt_q;
    src_d   = src_q;
    rdhi_d  = rdhi_q;
    stage_d = stage_q;
    we_lo   = 1'b0;
    we_hi   = 1'b0;
    buf_we  = 1'b0;
    if (ev) begin
      unique case (op)
        OP_END:   state_d = ST_IDLE;
        OP_WADDR: begin state_d = ST_WR; tgt_d = dreg; end
        OP_RADDR: begin state_d = ST_RD; src_d = dreg; rdhi_d = dhi; end
        OP_DATA: begin
          if (state_q == ST_WR) begin
            if (tgt_q == BUF_IDX) begin
              if (dhi) buf_we  = 1'b1;
              else     stage_d = dnib;
            end else if (dhi) begin
              we_hi = 1'b1;
            end else begin
              we_lo = 1'b1;
            end
          end else if (state_q == ST_RD) begin
            rdhi_d = dhi;
          end
        end
        default: ;
      endcase
    end
  end

  assign sel_cur = alt_q    ? ~alo_q    : rdhi_q;
  assign sel_nxt = alt_rd_i ? ~alt_lo_i : rdhi_d;
  assign bh_cur  = (state_q == ST_RD) && (src_q == BUF_IDX) && sel_cur;
  assign bh_nxt  = (state_d == ST_RD) && (src_d == BUF_IDX) && sel_nxt;
  assign adv     = bh_cur && !bh_nxt;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_IDLE;
      last_q  <= 8'hE0;
      tgt_q   <= '0;
      src_q   <= '0;
      rdhi_q  <= 1'b0;
      stage_q <= '0;
      alt_q   <= 1'b0;
      alo_q   <= 1'b0;
    end else begin
      if (ev) begin
        last_q  <= hd_i;
        state_q <= state_d;
        tgt_q   <= tgt_d;
        src_q   <= src_d;
        rdhi_q  <= rdhi_d;
        stage_q <= stage_d;
      end
      alt_q <= alt_rd_i;
      alo_q <= alt_lo_i;
    end
  end

  npt_regbank #(.NREG(NREG)) u_bank (
    .clk     (clk),
    .rst_n   (rst_sn),
    .wsel_i  (tgt_q),
    .we_lo_i (we_lo),
    .we_hi_i (we_hi),
    .nib_i   (dnib),
    .rsel_i  (src_q),
    .rdata_o (bank_rd)
  );

  npt_bufmem #(.DEPTH(DEPTH)) u_buf (
    .clk     (clk),
    .rst_n   (rst_sn),
    .wr_i    (buf_we),
    .wdata_i ({dnib, stage_q}),
    .adv_i   (adv),
    .rdata_o (buf_rd),
    .ptr_o   (buf_ptr)
  );

  assign src_byte = (src_q == BUF_IDX) ? buf_rd : bank_rd;
  assign nib_out  = sel_cur ? src_byte[BYTE_W-1:NIB_W] : src_byte[NIB_W-1:0];
  assign st_o     = (state_q == ST_RD) ? {1'b0, nib_out, 3'b000} : '0;
endmodule

// File: rtl/npt_checker.sv
module npt_checker
  import npt_pkg::*;
#(
  parameter int PW = 4
) (
  input logic              clk,
  input logic              rst_sn,
  input logic [BYTE_W-1:0] hd_i,
  input logic [BYTE_W-1:0] st_o,
  input npt_state_e        state_q,
  input logic [BYTE_W-1:0] last_q,
  input logic [RAW-1:0]    tgt_q,
  input logic [PW-1:0]     buf_ptr
);
  // R4: only the nibble lanes of the status byte ever carry data
  a_r4_spare_bits_low: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_o[7] == 1'b0) && (st_o[2:0] == 3'b000));

  // R2 and R10: an end code drops to idle with a quiet status byte
  a_r2_end_to_idle: assert property (@(posedge clk) disable iff (!rst_sn)
    (hd_i != last_q && hd_i[7:5] == 3'b111) |=> (state_q == ST_IDLE) && (st_o == 8'h00));

  // R3: a write-address code latches its register number
  a_r3_write_target: assert property (@(posedge clk) disable iff (!rst_sn)
    (hd_i != last_q && hd_i[7:5] == 3'b010) |=> (state_q == ST_WR) && (tgt_q == $past(hd_i[3:0])));

  // R5: a repeated byte leaves the command state untouched
  a_r5_repeat_inert: assert property (@(posedge clk) disable iff (!rst_sn)
    (hd_i == last_q) |=> $stable(state_q) && $stable(tgt_q) && $stable(last_q));

  // R7 and R8: the buffer pointer moves by at most one per clock
  a_r7_ptr_single_step: assert property (@(posedge clk) disable iff (!rst_sn)
    1'b1 |=> (buf_ptr == $past(buf_ptr)) || (buf_ptr == PW'($past(buf_ptr) + 1'b1)));
endmodule

bind nib_port_target npt_checker #(.PW(PW)) u_chk (
  .clk     (clk),
  .rst_sn  (rst_sn),
  .hd_i    (hd_i),
  .st_o    (st_o),
  .state_q (state_q),
  .last_q  (last_q),
  .tgt_q   (tgt_q),
  .buf_ptr (buf_ptr)
);

// File: tb/test_nib_port_target.sv
module test_nib_port_target;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] hd = 8'hE0;
  logic       alt = 1'b0;
  logic       alo = 1'b0;
  logic [7:0] st_o;

  int    n_chk = 0;
  int    n_err = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  nib_port_target i_nib_port_target (
    .clk      (clk),
    .rst_n    (rst_n),
    .hd_i     (hd),
    .alt_rd_i (alt),
    .alt_lo_i (alo),
    .st_o     (st_o)
  );

  // behavioural reference: 0 idle, 1 write, 2 read
  int mst, mtgt, msrc, mhi, mstage, mlast, malt, malo, maddr;
  int mreg [16];
  int mmem [16];

  task automatic mreset();
    mst = 0; mtgt = 0; msrc = 0; mhi = 0; mstage = 0;
    mlast = 'hE0; malt = 0; malo = 0; maddr = 0;
    for (int i = 0; i < 16; i++) begin mreg[i] = 0; mmem[i] = 0; end
  endtask

  function automatic int msel();
    return malt ? (malo ? 0 : 1) : mhi;
  endfunction

  function automatic int bufhi();
    return (mst == 2 && msrc == 14 && msel() == 1) ? 1 : 0;
  endfunction

  task automatic mstep();
    int cur, top, n, h;
    cur = bufhi();
    if (int'(hd) != mlast) begin
      mlast = int'(hd);
      top = mlast >> 5; n = mlast & 15; h = (mlast >> 4) & 1;
      if (top == 7) mst = 0;
      else if (top == 2) begin mst = 1; mtgt = n; end
      else if (top == 6) begin mst = 2; msrc = n; mhi = h; end
      else if (top <= 1) begin
        if (mst == 1) begin
          if (mtgt == 14) begin
            if (h == 1) begin mmem[maddr] = (n << 4) | mstage; maddr = (maddr + 1) % 16; end
            else mstage = n;
          end else if (mtgt < 14) begin
            if (h == 1) mreg[mtgt] = (mreg[mtgt] & 15) | (n << 4);
            else        mreg[mtgt] = (mreg[mtgt] & 'hF0) | n;
          end
        end else if (mst == 2) mhi = h;
      end
    end
    malt = int'(alt); malo = int'(alo);
    if (cur == 1 && bufhi() == 0) maddr = (maddr + 1) % 16;
  endtask

  function automatic logic [7:0] mexp();
    int b, nb;
    if (mst != 2) return 8'h00;
    b  = (msrc < 14) ? mreg[msrc] : ((msrc == 14) ? mmem[maddr] : 0);
    nb = (msel() == 1) ? (b >> 4) : (b & 15);
    return 8'(nb << 3);
  endfunction

  always @(posedge clk) begin
    logic [7:0] e;
    if (!rst_n) mreset(); else mstep();
    #2;
    e = mexp();
    n_chk++;
    if (st_o !== e) begin
      n_err++;
      $display("FAIL %s (per-clock model) st_o=%h expected=%h at %0t", cur_req, st_o, e, $time);
    end
  end

  task automatic chk(input logic [7:0] exp, input string tag);
    n_chk++;
    if (st_o !== exp) begin
      n_err++;
      $display("FAIL %s st_o=%h expected=%h at %0t", tag, st_o, exp, $time);
    end
  endtask

  task automatic chknib(input logic [7:0] b, input bit hi, input string tag);
    chk(hi ? {1'b0, b[7:4], 3'b000} : {1'b0, b[3:0], 3'b000}, tag);
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk); hd = b;
    @(negedge clk);
  endtask

  task automatic writereg(input logic [3:0] r, input logic [7:0] v);
    put({4'h4, r}); put({4'h0, v[3:0]}); put({4'h1, v[7:4]}); put(8'hE0);
  endtask

  task automatic readreg(input logic [3:0] r, input logic [7:0] v, input string tag);
    put({4'hC, r}); chknib(v, 1'b0, tag);
    put(8'h10);     chknib(v, 1'b1, tag);
    put(8'hE0);     chk(8'h00, tag);
  endtask

  function automatic logic [7:0] vpat(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    cur_req = "R1";
    chk(8'h00, "R1 idle after reset");
    readreg(4'd0, 8'h00, "R1 reg0 zero");
    readreg(4'd13, 8'h00, "R1 reg13 zero");

    cur_req = "R3";
    writereg(4'd3, 8'hA5);
    cur_req = "R4";
    readreg(4'd3, 8'hA5, "R4 reg3 nibbles");
    put(8'hD3); chknib(8'hA5, 1'b1, "R4 high select in command");
    put(8'hE0);

    cur_req = "R5";
    put(8'h44); put(8'h44); put(8'h07); put(8'h07); put(8'h13); put(8'h13); put(8'hE4);
    readreg(4'd4, 8'h37, "R5 doubled register write");

    cur_req = "R2";
    put(8'h0F); put(8'h1F); put(8'hE0);
    readreg(4'd4, 8'h37, "R2 idle nibbles ignored");
    chk(8'h00, "R10 status quiet when idle");

    cur_req = "R6";
    alt = 1'b1; alo = 1'b1;
    put(8'hC3); chknib(8'hA5, 1'b0, "R6 control low select");
    @(negedge clk); alo = 1'b0; @(negedge clk);
    chknib(8'hA5, 1'b1, "R6 control high select");
    @(negedge clk); alt = 1'b0; @(negedge clk);
    put(8'hE0);

    cur_req = "R7";
    put(8'h4E);
    for (int i = 0; i < 16; i++) begin
      logic [7:0] v;
      v = vpat(i);
      put({4'h0, v[3:0]}); put({4'h1, v[7:4]});
    end
    put(8'hE0);

    cur_req = "R8";
    for (int i = 0; i < 16; i++) begin
      put(i == 0 ? 8'hCE : 8'h00); chknib(vpat(i), 1'b0, "R8 buffer read low");
      put(8'h10);                  chknib(vpat(i), 1'b1, "R8 buffer read high");
    end
    put(8'hE0); chk(8'h00, "R10 quiet after buffer read");

    cur_req = "R5";
    put(8'h4E); put(8'h09); put(8'h09); put(8'h1C); put(8'h1C); put(8'hE0);
    for (int i = 1; i <= 16; i++) begin
      logic [7:0] b;
      b = (i == 16) ? 8'hC9 : vpat(i);
      put(i == 1 ? 8'hCE : 8'h00); chknib(b, 1'b0, "R5 R7 single store and wrap");
      put(8'h10);                  chknib(b, 1'b1, "R7 wrapped byte");
    end
    put(8'hE0);

    cur_req = "R9";
    writereg(4'd15, 8'h5F);
    readreg(4'd15, 8'h00, "R9 reg15 reads zero");
    put(8'h43); put(8'h0C); put(8'h80); put(8'h1D); put(8'hE0);
    readreg(4'd3, 8'hDC, "R9 reserved code in write");
    put(8'hC3); chknib(8'hDC, 1'b0, "R9 read low");
    put(8'hA5); chknib(8'hDC, 1'b0, "R9 reserved code in read");
    put(8'h10); chknib(8'hDC, 1'b1, "R9 read high");
    put(8'hE0); chk(8'h00, "R10 final idle");

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule